// File: doc/BRIEF.md
# Prioritised Display Page Selector

This block chooses the page identifier that one display unit shows. After reset it walks a fixed startup sequence: an initialisation page, then a boot page, then a default auxiliary-power page. Once startup is over it follows the flight phase. A pilot selection, latched from a one-cycle strobe, takes precedence over everything else. Next come subsystem fault pages, chosen by a fixed priority order. Flight-phase pages rank lowest.

While a selection or fault page is on screen, the choice is revisited only at a slow, fixed interval, so the page does not flicker. The block falls back to flight-phase pages once a minimum dwell has passed and no selection and no fault remain. Both intervals are counted in pulses of a `tick` input, for example one pulse per second. A system with several display units uses one instance per unit.

Top module: `page_sel`

## Requirements
- R1: After reset the page is 0 (initialisation). It stays 0 until `initDone` is sampled high, whatever the fault, selection and phase inputs do.
- R2: `initDone` high in the initialisation state gives page 1 (boot) on the next cycle. `bootDone` high in the boot state gives page 2 (auxiliary power, the default) on the next cycle.
- R3: In the default-page state, `engStart` high with phase 0 gives page 3 (engines) on the next cycle.
- R4: In either post-boot startup state (page 2 or 3), a nonzero phase enters normal mode and the page becomes 8 + phase on the next cycle. Faults and selections do not change the page while in these states.
- R5: In normal mode with no latched selection and no fault, the page is 8 + phase. It is updated every cycle with one cycle of latency.
- R6: A `selStrobe` pulse latches `selPage` as a valid selection, and a later strobe replaces it. `selClear` drops the selection. When both arrive in the same cycle, the strobe wins.
- R7: In normal mode, a latched selection or any fault moves to the priority mode on the next cycle. The page becomes the selected code if a selection is latched, otherwise the fault page.
- R8: The fault page is 4 + i, where i is the lowest-numbered set bit of `faults` (bit 0 has top priority).
- R9: In priority mode the page is held, except on every RECHECK_TICKS-th tick counted from entry. On that tick the choice is redone from the top (selection, then fault). If neither is present at that tick, the page is kept.
- R10: Priority mode is left only after HOLD_TICKS ticks have been counted since entry. After that, any cycle with no selection and no fault gives page 8 + phase on the next cycle. Before that, the block stays in priority mode.
- R11: Both dwell counters advance only on cycles with `tick` high and restart at 0 on every entry into priority mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base pulse for the dwell counters |
| initDone | input | 1 | Initialisation finished |
| bootDone | input | 1 | Boot finished |
| engStart | input | 1 | Engine start indication |
| phase | input | PHASE_W | Current flight-phase code |
| faults | input | NUM_FAULTS | Per-subsystem fault flags, bit 0 highest priority |
| selStrobe | input | 1 | One-cycle pilot selection strobe |
| selPage | input | 4 | Page code carried by the selection strobe |
| selClear | input | 1 | Drops the latched pilot selection |
| pageId | output | 4 | Page identifier shown on the unit |

## Verification
The bench builds the block with HOLD_TICKS = 3 and RECHECK_TICKS = 5 instead of one and five seconds' worth of ticks. This keeps dwell expiry, re-evaluation boundaries and early-exit refusal within a few dozen cycles. With a dwell of three ticks, a fault that clears quickly can be shown to be held. Gating `tick` low shows that neither counter moves without it. Four fault bits and a three-bit phase cover every fault page and every phase page in a long mixed-stimulus run that includes a mid-run reset.

// File: rtl/page_sel_pkg.sv
package page_sel_pkg;
  localparam int PAGE_W = 4;

  localparam logic [PAGE_W-1:0] PG_INIT    = 4'd0;
  localparam logic [PAGE_W-1:0] PG_BOOT    = 4'd1;
  localparam logic [PAGE_W-1:0] PG_APU     = 4'd2;
  localparam logic [PAGE_W-1:0] PG_ENG     = 4'd3;
  localparam logic [PAGE_W-1:0] FAULT_BASE = 4'd4;
  localparam logic [PAGE_W-1:0] PHASE_BASE = 4'd8;

  typedef enum logic [2:0] {
    ST_INIT, ST_BOOT, ST_APU, ST_ENG, ST_NORMAL, ST_PRIO
  } selState_t;

  typedef enum logic [2:0] {
    SRC_HOLD, SRC_INIT, SRC_BOOT, SRC_APU, SRC_ENG, SRC_PHASE, SRC_ARB
  } pageSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    pageSrc_t pageSrc;
    logic     timerClr;
  } ctrlStrb_t;
endpackage

// File: rtl/page_sel_ctrl.sv
module page_sel_ctrl
  import page_sel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      initDone,
  input  logic      bootDone,
  input  logic      engStart,
  input  logic      phaseNz,
  input  logic      selValid,
  input  logic      anyFault,
  input  logic      holdDone,
  input  logic      recheckDue,
  output selState_t curState,
  output ctrlStrb_t strb
);
  selState_t nxtState;
  logic      wantPrio;

  assign wantPrio = selValid | anyFault;

  always_comb begin
    nxtState      = curState;
    strb.pageSrc  = SRC_HOLD;
    strb.timerClr = 1'b0;
    case (curState)
      ST_INIT: if (initDone) begin
        nxtState     = ST_BOOT;
        strb.pageSrc = SRC_BOOT;
      end
      ST_BOOT: if (bootDone) begin
        nxtState     = ST_APU;
        strb.pageSrc = SRC_APU;
      end
      ST_APU: begin
        if (phaseNz) begin
          nxtState     = ST_NORMAL;
          strb.pageSrc = SRC_PHASE;
        end else if (engStart) begin
          nxtState     = ST_ENG;
          strb.pageSrc = SRC_ENG;
        end
      end
      ST_ENG: if (phaseNz) begin
        nxtState     = ST_NORMAL;
        strb.pageSrc = SRC_PHASE;
      end
      ST_NORMAL: begin
        if (wantPrio) begin
          nxtState      = ST_PRIO;
          strb.pageSrc  = SRC_ARB;
          strb.timerClr = 1'b1;
        end else begin
          strb.pageSrc = SRC_PHASE;
        end
      end
      ST_PRIO: begin
        if (holdDone && !wantPrio) begin
          nxtState     = ST_NORMAL;
          strb.pageSrc = SRC_PHASE;
        end else if (recheckDue && wantPrio) begin
          strb.pageSrc = SRC_ARB;
        end
      end
      default: nxtState = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) curState <= ST_INIT;
    else        curState <= nxtState;
  end
endmodule

// File: rtl/page_sel_dp.sv
module page_sel_dp
  import page_sel_pkg::*;
#(
  parameter int NUM_FAULTS    = 4,
  parameter int PHASE_W       = 3,
  parameter int HOLD_TICKS    = 1,
  parameter int RECHECK_TICKS = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  inPrio,
  input  ctrlStrb_t             strb,
  input  logic [PHASE_W-1:0]    phase,
  input  logic [NUM_FAULTS-1:0] faults,
  input  logic                  selStrobe,
  input  logic [PAGE_W-1:0]     selPage,
  input  logic                  selClear,
  output logic                  selValid,
  output logic [PAGE_W-1:0]     selCode,
  output logic                  anyFault,
  output logic                  holdDone,
  output logic                  recheckDue,
  output logic [PAGE_W-1:0]     pageId
);
  localparam int IDX_W  = (NUM_FAULTS > 1) ? $clog2(NUM_FAULTS) : 1;
  localparam int HOLD_W = $clog2(HOLD_TICKS + 1);
  localparam int RCK_W  = $clog2(RECHECK_TICKS + 1);

  logic [IDX_W-1:0]  faultIdx;
  logic [PAGE_W-1:0] arbPage;
  logic [HOLD_W-1:0] holdCnt;
  logic [RCK_W-1:0]  recheckCnt;
  logic [PAGE_W-1:0] pageQ;

  // pilot selection latch, strobe beats clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selValid <= 1'b0;
      selCode  <= '0;
    end else if (selStrobe) begin
      selValid <= 1'b1;
      selCode  <= selPage;
    end else if (selClear) begin
      selValid <= 1'b0;
    end
  end

  // fixed-order fault encoder, lowest bit first
  assign anyFault = |faults;
  generate
    if (NUM_FAULTS == 1) begin : g_oneFault
      assign faultIdx = '0;
    end else begin : g_prioEnc
      always_comb begin
        faultIdx = '0;
        for (int i = NUM_FAULTS - 1; i >= 0; i--) begin
          if (faults[i]) faultIdx = IDX_W'(i);
        end
      end
    end
  endgenerate

  assign arbPage = selValid ? selCode : (FAULT_BASE + PAGE_W'(faultIdx));

  // dwell counters in tick units
  assign holdDone   = (holdCnt == HOLD_W'(HOLD_TICKS));
  assign recheckDue = inPrio && tick && (recheckCnt == RCK_W'(RECHECK_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdCnt    <= '0;
      recheckCnt <= '0;
    end else if (strb.timerClr) begin
      holdCnt    <= '0;
      recheckCnt <= '0;
    end else if (inPrio && tick) begin
      if (!holdDone) holdCnt <= holdCnt + 1'b1;
      recheckCnt <= recheckDue ? '0 : recheckCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pageQ <= PG_INIT;
    else begin
      case (strb.pageSrc)
        SRC_INIT:  pageQ <= PG_INIT;
        SRC_BOOT:  pageQ <= PG_BOOT;
        SRC_APU:   pageQ <= PG_APU;
        SRC_ENG:   pageQ <= PG_ENG;
        SRC_PHASE: pageQ <= PHASE_BASE + PAGE_W'(phase);
        SRC_ARB:   pageQ <= arbPage;
        default:   pageQ <= pageQ;
      endcase
    end
  end

  assign pageId = pageQ;
endmodule

// File: rtl/page_sel.sv
module page_sel
  import page_sel_pkg::*;
#(
  parameter int NUM_FAULTS    = 4,
  parameter int PHASE_W       = 3,
  parameter int HOLD_TICKS    = 1,
  parameter int RECHECK_TICKS = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  initDone,
  input  logic                  bootDone,
  input  logic                  engStart,
  input  logic [PHASE_W-1:0]    phase,
  input  logic [NUM_FAULTS-1:0] faults,
  input  logic                  selStrobe,
  input  logic [3:0]            selPage,
  input  logic                  selClear,
  output logic [3:0]            pageId
);
  selState_t         curState;
  ctrlStrb_t         strb;
  logic              selValid;
  logic [PAGE_W-1:0] selCode;
  logic              anyFault;
  logic              holdDone;
  logic              recheckDue;
  logic              phaseNz;

  assign phaseNz = |phase;

  page_sel_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .initDone(initDone), .bootDone(bootDone), .engStart(engStart),
    .phaseNz(phaseNz), .selValid(selValid), .anyFault(anyFault),
    .holdDone(holdDone), .recheckDue(recheckDue),
    .curState(curState), .strb(strb)
  );

  page_sel_dp #(
    .NUM_FAULTS(NUM_FAULTS), .PHASE_W(PHASE_W),
    .HOLD_TICKS(HOLD_TICKS), .RECHECK_TICKS(RECHECK_TICKS)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .inPrio(curState == ST_PRIO), .strb(strb),
    .phase(phase), .faults(faults),
    .selStrobe(selStrobe), .selPage(selPage), .selClear(selClear),
    .selValid(selValid), .selCode(selCode), .anyFault(anyFault),
    .holdDone(holdDone), .recheckDue(recheckDue), .pageId(pageId)
  );
endmodule

// File: rtl/page_sel_chk.sv
module page_sel_chk
  import page_sel_pkg::*;
#(
  parameter int PHASE_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               initDone,
  input logic               engStart,
  input logic [PHASE_W-1:0] phase,
  input logic [3:0]         pageId,
  input selState_t          curState,
  input logic               selValid,
  input logic [3:0]         selCode,
  input logic               anyFault,
  input logic               holdDone,
  input logic               recheckDue,
  input logic               phaseNz
);
  assert_init_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_INIT && !initDone) |=> (pageId == PG_INIT));

  assert_boot_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_INIT && initDone) |=> (pageId == PG_BOOT && curState == ST_BOOT));

  assert_startup_ignores_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((curState == ST_APU || curState == ST_ENG) && !phaseNz && !engStart) |=> $stable(pageId));

  assert_phase_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_NORMAL && !selValid && !anyFault) |=> (pageId == PHASE_BASE + 4'($past(phase))));

  assert_sel_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_NORMAL && selValid) |=> (pageId == $past(selCode)));

  assert_no_flicker_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_PRIO && !recheckDue && !(holdDone && !selValid && !anyFault)) |=> $stable(pageId));

  assert_min_dwell_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_PRIO && !holdDone) |=> (curState == ST_PRIO));
endmodule

bind page_sel page_sel_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .initDone(initDone), .engStart(engStart),
  .phase(phase), .pageId(pageId), .curState(curState),
  .selValid(selValid), .selCode(selCode), .anyFault(anyFault),
  .holdDone(holdDone), .recheckDue(recheckDue), .phaseNz(phaseNz)
);

// File: tb/tb_page_sel.sv
module tb_page_sel;
  localparam int CLK_PERIOD = 10;
  localparam int NF    = 4;
  localparam int PW    = 3;
  localparam int HOLD  = 3;
  localparam int RECHK = 5;
  localparam int M_INIT = 0, M_BOOT = 1, M_APU = 2, M_ENG = 3, M_NORM = 4, M_PRIO = 5;

  logic clk = 0, rst_n = 0, tick = 1;
  logic initDone = 0, bootDone = 0, engStart = 0;
  logic selStrobe = 0, selClear = 0;
  logic [PW-1:0] phase = '0;
  logic [NF-1:0] faults = '0;
  logic [3:0] selPage = '0;
  wire  [3:0] pageId;

  int checks = 0, failures = 0;
  string curReq = "R1";
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_sel #(.NUM_FAULTS(NF), .PHASE_W(PW), .HOLD_TICKS(HOLD), .RECHECK_TICKS(RECHK)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .initDone(initDone), .bootDone(bootDone),
    .engStart(engStart), .phase(phase), .faults(faults), .selStrobe(selStrobe),
    .selPage(selPage), .selClear(selClear), .pageId(pageId)
  );

  // behavioural reference model
  int mMode, mPage, mSelC, mHc, mRc, nMode, nPage, fIdx, arb;
  bit mSelV, anyF, hDone, due, clr, want;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mMode = M_INIT; mPage = 0; mSelV = 0; mSelC = 0; mHc = 0; mRc = 0;
    end else begin
      anyF  = (faults != 0);
      want  = mSelV || anyF;
      hDone = (mHc >= HOLD);
      due   = (mMode == M_PRIO) && tick && (mRc == RECHK - 1);
      fIdx  = 0;
      for (int i = NF - 1; i >= 0; i--) if (faults[i]) fIdx = i;
      arb   = mSelV ? mSelC : 4 + fIdx;
      nMode = mMode; nPage = mPage; clr = 0;
      if (mMode == M_INIT) begin
        if (initDone) begin nMode = M_BOOT; nPage = 1; end
      end else if (mMode == M_BOOT) begin
        if (bootDone) begin nMode = M_APU; nPage = 2; end
      end else if (mMode == M_APU || mMode == M_ENG) begin
        if (phase != 0) begin nMode = M_NORM; nPage = 8 + int'(phase); end
        else if (mMode == M_APU && engStart) begin nMode = M_ENG; nPage = 3; end
      end else if (mMode == M_NORM) begin
        if (want) begin nMode = M_PRIO; nPage = arb; clr = 1; end
        else nPage = 8 + int'(phase);
      end else begin
        if (hDone && !want) begin nMode = M_NORM; nPage = 8 + int'(phase); end
        else if (due && want) nPage = arb;
      end
      if (clr) begin mHc = 0; mRc = 0; end
      else if (mMode == M_PRIO && tick) begin
        if (mHc < HOLD) mHc++;
        mRc = (mRc == RECHK - 1) ? 0 : mRc + 1;
      end
      if (selStrobe) begin mSelV = 1; mSelC = int'(selPage); end
      else if (selClear) mSelV = 0;
      mMode = nMode; mPage = nPage;
    end
  end

  task automatic cyc();
    @(negedge clk);
    checks++;
    if (pageId !== 4'(mPage)) begin
      failures++;
      $display("FAIL %s page actual=%0d expected=%0d t=%0t", curReq, pageId, mPage, $time);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic expectPage(input int exp, input string req);
    checks++;
    if (pageId !== 4'(exp)) begin
      failures++;
      $display("FAIL %s directed actual=%0d expected=%0d", req, pageId, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset and hold in init
    curReq = "R1";
    cycles(4);
    expectPage(0, "R1");
    rst_n = 1; faults = 4'b1111; phase = 3'd4;
    cycles(5);
    expectPage(0, "R1");
    // R2 startup walk
    curReq = "R2";
    initDone = 1; cyc(); initDone = 0;
    cycles(3); expectPage(1, "R2");
    phase = 0;
    bootDone = 1; cyc(); bootDone = 0;
    cycles(3); expectPage(2, "R2");
    // R4 faults and selection do not disturb startup pages
    curReq = "R4";
    selPage = 4'd7; selStrobe = 1; cyc(); selStrobe = 0;
    cycles(5); expectPage(2, "R4");
    // R3 engine start
    curReq = "R3";
    engStart = 1; cyc(); engStart = 0;
    cycles(3); expectPage(3, "R3");
    // R4 leave startup on nonzero phase
    curReq = "R4";
    selClear = 1; cyc(); selClear = 0;
    faults = '0; phase = 3'd2;
    cycles(3); expectPage(10, "R4");
    // R5 phase tracking
    curReq = "R5";
    phase = 3'd5; cycles(2); expectPage(13, "R5");
    phase = 3'd0; cycles(2); expectPage(8, "R5");
    phase = 3'd5; cycles(2); expectPage(13, "R5");
    // R8 fault order
    curReq = "R8";
    faults = 4'b1010; cycles(3); expectPage(5, "R8");
    // R9 re-evaluation only at interval
    curReq = "R9";
    faults = 4'b0011; cycles(12); expectPage(4, "R9");
    // R7 selection beats fault
    curReq = "R7";
    selPage = 4'd9; selStrobe = 1; cyc(); selStrobe = 0;
    cycles(12); expectPage(9, "R7");
    // R10 return to phase pages
    curReq = "R10";
    selClear = 1; faults = '0; cyc(); selClear = 0;
    cycles(12); expectPage(13, "R10");
    // R6 strobe wins over simultaneous clear
    curReq = "R6";
    selPage = 4'd14; selStrobe = 1; selClear = 1; cyc(); selStrobe = 0; selClear = 0;
    cycles(4); expectPage(14, "R6");
    selClear = 1; cyc(); selClear = 0;
    cycles(8); expectPage(13, "R6");
    // R11 counters frozen without tick
    curReq = "R11";
    faults = 4'b0001; cycles(2); expectPage(4, "R11");
    tick = 0; faults = '0;
    cycles(20); expectPage(4, "R11");
    curReq = "R10";
    tick = 1; cycles(6); expectPage(13, "R10");
    // mixed stimulus, with a reset in the middle
    curReq = "R9";
    for (int r = 0; r < 2; r++) begin
      if (r == 1) begin
        curReq = "R1";
        rst_n = 0; cycles(2); rst_n = 1;
        curReq = "R7";
      end
      for (int k = 0; k < 3000; k++) begin
        tick      = ($urandom % 2) == 0;
        initDone  = ($urandom % 8) == 0;
        bootDone  = ($urandom % 8) == 0;
        engStart  = ($urandom % 16) == 0;
        selStrobe = ($urandom % 25) == 0;
        selClear  = ($urandom % 15) == 0;
        selPage   = 4'($urandom);
        if (($urandom % 10) == 0) phase = PW'($urandom);
        if (($urandom % 30) == 0) faults = (($urandom % 3) == 0) ? NF'($urandom) : '0;
        cyc();
      end
    end
    finished = 1;
    summary();
    $finish;
  end
endmodule